// File: doc/BRIEF.md
# Host Data Port Transfer Engine

This block sits between a host register interface and the memories of a coprocessor and moves 16-bit words between them. The host sees four registers: a data port, an address register, a configuration register and a read-only status register. Writing the data port sends the word straight to the selected coprocessor memory at the current address. Reading the data port takes words from a prefetch FIFO. A burst started through the configuration register fills that FIFO, and it is topped up again each time the host pops a word while words of the burst are still owed.

A 3-bit field in the configuration register steers every access to one of four memory spaces, and an optional auto-increment steps the address after each access. The coprocessor side is a simple word request port with a valid/ready handshake and a fixed one-cycle read latency. The block also drives a level output that holds the coprocessor in reset, a one-cycle pulse when that hold is written, and a single interrupt pulse output.

Top module: `hdp_engine`

## Requirements
- R1: Config bits [14:12] pick the target. Code 0 is data memory (`mem_space`=0, full address). Code 1 is register space (`mem_space`=1, only the low 11 address bits, upper bits zero). Code 5 is program memory (`mem_space`=2). Code 7 is the external bus (`mem_space`=3). Every other code makes no memory request: a write has no effect, and each word a burst would fetch enters the FIFO as 0.
- R2: When config bit 1 is set, the 16-bit address grows by one after each memory access and wraps from 0xFFFF to 0x0000. When the bit is clear, or no access took place, the address keeps its value. The address register (host select 1) reads back the current address.
- R3: Config bits [3:2] set the burst length: 0 is 1 word, 1 is 8 words, 2 is 16 words and 3 is an endless stream.
- R4: A config write (host select 2) with bit 4 set flushes the FIFO and starts a burst. It fetches min(16, length) words before the host interface is ready again, then pulses `irq`.
- R5: A config write with bit 4 clear flushes the FIFO and drops every word still owed. A later pop returns 0.
- R6: A data-port read (host select 0) while words are owed first fetches as many words as the FIFO has free entries, limited to the remaining count for a finite burst. It then returns the oldest word. The words come out in fetch order.
- R7: A data-port read with nothing owed returns the oldest buffered word if one exists, and 0 otherwise.
- R8: The status register (host select 3) reads bit 0 = FIFO not empty, bit 5 = FIFO full, bit 6 = FIFO not empty and bit 8 = 1. All other bits read 0.
- R9: `irq` pulses once after each burst fill, once after each data-port write that reaches memory, and once after each pop that leaves the FIFO non-empty.
- R10: `cop_hold` follows config bit 0. A config write with bit 0 set gives a one-cycle `cop_reset_pulse`.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request fields stay unchanged. Read data is taken from `mem_rdata` one cycle after the read is accepted.
- R12: After reset the address, config and FIFO are cleared, nothing is owed, the status register reads 0x0100, and `irq` and `host_rvalid` are low.
- R13: A data-port write to a valid region makes one write request carrying the host word at the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, taken when `host_ready` is high |
| host_we | input | 1 | 1 = register write, 0 = register read |
| host_sel | input | 2 | Register select: 0 data port, 1 address, 2 config, 3 status |
| host_wdata | input | 16 | Host write data |
| host_ready | output | 1 | Engine idle and able to take a request |
| host_rvalid | output | 1 | One-cycle pulse marking `host_rdata` valid |
| host_rdata | output | 16 | Read result |
| irq | output | 1 | Interrupt pulse |
| cop_hold | output | 1 | Holds the coprocessor in reset |
| cop_reset_pulse | output | 1 | One-cycle reset pulse on a config write with bit 0 set |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write request |
| mem_space | output | 2 | Target space: 0 data, 1 registers, 2 program, 3 external |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read is accepted |

## Verification
The bench builds the engine with its default parameters: 16-bit words and addresses, a 16-entry FIFO, an 11-bit register space and burst lengths of 8 and 16. With these values a 16-word burst fills the FIFO exactly, so the full flag and the refill-of-zero case can both be reached. An endless stream started near 0xFFFF takes the address through its wrap within a few pops. Random backpressure on the memory ready line stretches every fill, which tests both the stable-request rule and the one-cycle capture of read data.

// File: rtl/hdp_pkg.sv
package hdp_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_STAT = 2'd3
  } host_sel_e;

  typedef enum logic [1:0] {
    SP_DATA = 2'd0,
    SP_REGS = 2'd1,
    SP_PROG = 2'd2,
    SP_EXT  = 2'd3
  } mem_space_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PLAN  = 2'd1,
    ST_FILL  = 2'd2,
    ST_WRITE = 2'd3
  } eng_state_e;

  // configuration register fields
  localparam int CFG_HOLD   = 0;
  localparam int CFG_AINC   = 1;
  localparam int CFG_LEN_LO = 2;
  localparam int CFG_START  = 4;
  localparam int CFG_REG_LO = 12;

  // status register fields
  localparam int STS_NE_LO  = 0;
  localparam int STS_FULL   = 5;
  localparam int STS_NE_HI  = 6;
  localparam int STS_WEMPTY = 8;

endpackage

// File: rtl/hdp_fifo.sv
module hdp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] count;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign head  = store[rd_ptr];
  assign level = count;
  assign full  = (count == LW'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/hdp_region_map.sv
module hdp_region_map #(
  parameter int AW  = 16,
  parameter int RAW = 11
) (
  input  logic [2:0]    code,
  input  logic [AW-1:0] addr,
  output logic          valid,
  output logic [1:0]    space,
  output logic [AW-1:0] maddr
);
  import hdp_pkg::*;

  logic [AW-1:0] reg_addr;

  generate
    if (RAW >= AW) begin : g_full_regs
      assign reg_addr = addr;
    end else begin : g_narrow_regs
      assign reg_addr = {{(AW-RAW){1'b0}}, addr[RAW-1:0]};
    end
  endgenerate

  always_comb begin
    valid = 1'b1;
    space = SP_DATA;
    maddr = addr;
    case (code)
      3'd0: space = SP_DATA;
      3'd1: begin
        space = SP_REGS;
        maddr = reg_addr;
      end
      3'd5: space = SP_PROG;
      3'd7: space = SP_EXT;
      default: valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/hdp_burst.sv
module hdp_burst #(
  parameter int DEPTH    = 16,
  parameter int MID_LEN  = 8,
  parameter int LONG_LEN = 16,
  localparam int LW      = $clog2(DEPTH + 1),
  localparam int CW      = $clog2(LONG_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    len_code,
  input  logic          cancel,
  input  logic          take,
  input  logic [LW-1:0] free,
  output logic          outstanding,
  output logic [LW-1:0] quota
);

  logic [CW-1:0] rem_q;
  logic          endless_q;

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      rem_q     <= '0;
      endless_q <= 1'b0;
    end else if (start) begin
      endless_q <= (len_code == 2'd3);
      case (len_code)
        2'd0:    rem_q <= CW'(1);
        2'd1:    rem_q <= CW'(MID_LEN);
        2'd2:    rem_q <= CW'(LONG_LEN);
        default: rem_q <= '0;
      endcase
    end else if (take && !endless_q && rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign outstanding = endless_q || (rem_q != '0);

  always_comb begin
    int r;
    int f;
    r = int'(rem_q);
    f = int'(free);
    if (endless_q || f < r) quota = free;
    else                    quota = LW'(r);
  end

endmodule

// File: rtl/hdp_engine.sv
module hdp_engine #(
  parameter int DW       = 16,
  parameter int AW       = 16,
  parameter int DEPTH    = 16,
  parameter int RAW      = 11,
  parameter int MID_LEN  = 8,
  parameter int LONG_LEN = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [1:0]    host_sel,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ready,
  output logic          host_rvalid,
  output logic [DW-1:0] host_rdata,
  output logic          irq,
  output logic          cop_hold,
  output logic          cop_reset_pulse,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_we,
  output logic [1:0]    mem_space,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  import hdp_pkg::*;

  localparam int LW = $clog2(DEPTH + 1);

  eng_state_e    state_q;
  logic [DW-1:0] cfg_q, wdata_q, rdata_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] fill_left_q;
  logic          inflight_q, pop_pend_q, rvalid_q, irq_q, rstp_q;

  logic          acc, cfg_wr;
  logic          region_valid;
  logic [1:0]    region_space;
  logic [AW-1:0] region_addr;
  logic          fill_active, mem_accept, rd_accept, zero_push, take, fill_done;
  logic          fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [DW-1:0] fifo_head, fifo_wdata;
  logic [LW-1:0] fifo_level, fifo_free, quota;
  logic          outstanding;
  logic [DW-1:0] status;

  assign host_ready = (state_q == ST_IDLE);
  assign acc        = host_req && host_ready;
  assign cfg_wr     = acc && host_we && (host_sel == SEL_CFG);

  hdp_region_map #(.AW(AW), .RAW(RAW)) u_map (
    .code  (cfg_q[CFG_REG_LO +: 3]),
    .addr  (addr_q),
    .valid (region_valid),
    .space (region_space),
    .maddr (region_addr)
  );

  assign fill_active   = (state_q == ST_FILL) && (fill_left_q != '0);
  assign mem_req_valid = (state_q == ST_WRITE) || (fill_active && region_valid);
  assign mem_we        = (state_q == ST_WRITE);
  assign mem_space     = region_space;
  assign mem_addr      = region_addr;
  assign mem_wdata     = wdata_q;
  assign mem_accept    = mem_req_valid && mem_req_ready;
  assign rd_accept     = mem_accept && !mem_we;
  assign zero_push     = fill_active && !region_valid;
  assign take          = rd_accept || zero_push;
  assign fill_done     = (state_q == ST_FILL) && (fill_left_q == '0) && !inflight_q;

  assign fifo_push  = inflight_q || zero_push;
  assign fifo_wdata = inflight_q ? mem_rdata : '0;
  assign fifo_pop   = (fill_done && pop_pend_q) ||
                      (acc && !host_we && (host_sel == SEL_DATA) && !outstanding && !fifo_empty);
  assign fifo_free  = LW'(DEPTH) - fifo_level;

  hdp_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (cfg_wr),
    .push      (fifo_push),
    .push_data (fifo_wdata),
    .pop       (fifo_pop),
    .head      (fifo_head),
    .level     (fifo_level),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  hdp_burst #(.DEPTH(DEPTH), .MID_LEN(MID_LEN), .LONG_LEN(LONG_LEN)) u_burst (
    .clk         (clk),
    .rst         (rst),
    .start       (cfg_wr && host_wdata[CFG_START]),
    .len_code    (host_wdata[CFG_LEN_LO +: 2]),
    .cancel      (cfg_wr && !host_wdata[CFG_START]),
    .take        (take),
    .free        (fifo_free),
    .outstanding (outstanding),
    .quota       (quota)
  );

  always_comb begin
    status             = '0;
    status[STS_NE_LO]  = !fifo_empty;
    status[STS_FULL]   = fifo_full;
    status[STS_NE_HI]  = !fifo_empty;
    status[STS_WEMPTY] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cfg_q       <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      addr_q      <= '0;
      fill_left_q <= '0;
      inflight_q  <= 1'b0;
      pop_pend_q  <= 1'b0;
      rvalid_q    <= 1'b0;
      irq_q       <= 1'b0;
      rstp_q      <= 1'b0;
    end else begin
      rvalid_q   <= 1'b0;
      irq_q      <= 1'b0;
      rstp_q     <= 1'b0;
      inflight_q <= rd_accept;
      if (mem_accept && cfg_q[CFG_AINC]) addr_q <= addr_q + 1'b1;

      case (state_q)
        ST_IDLE: begin
          if (acc && host_we) begin
            case (host_sel)
              SEL_ADDR: addr_q <= AW'(host_wdata);
              SEL_CFG: begin
                cfg_q  <= host_wdata;
                rstp_q <= host_wdata[CFG_HOLD];
                if (host_wdata[CFG_START]) begin
                  pop_pend_q <= 1'b0;
                  state_q    <= ST_PLAN;
                end
              end
              SEL_DATA: begin
                if (region_valid) begin
                  wdata_q <= host_wdata;
                  state_q <= ST_WRITE;
                end
              end
              default: ;
            endcase
          end else if (acc) begin
            case (host_sel)
              SEL_DATA: begin
                if (outstanding) begin
                  pop_pend_q <= 1'b1;
                  state_q    <= ST_PLAN;
                end else begin
                  rvalid_q <= 1'b1;
                  rdata_q  <= fifo_empty ? '0 : fifo_head;
                  irq_q    <= (fifo_level > LW'(1));
                end
              end
              SEL_ADDR: begin
                rvalid_q <= 1'b1;
                rdata_q  <= DW'(addr_q);
              end
              SEL_CFG: begin
                rvalid_q <= 1'b1;
                rdata_q  <= cfg_q;
              end
              default: begin
                rvalid_q <= 1'b1;
                rdata_q  <= status;
              end
            endcase
          end
        end
        ST_PLAN: begin
          fill_left_q <= quota;
          state_q     <= ST_FILL;
        end
        ST_FILL: begin
          if (take) fill_left_q <= fill_left_q - 1'b1;
          if (fill_done) begin
            state_q <= ST_IDLE;
            if (pop_pend_q) begin
              pop_pend_q <= 1'b0;
              rvalid_q   <= 1'b1;
              rdata_q    <= fifo_head;
              irq_q      <= (fifo_level > LW'(1));
            end else begin
              irq_q <= 1'b1;
            end
          end
        end
        default: begin
          if (mem_accept) begin
            irq_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign host_rvalid     = rvalid_q;
  assign host_rdata      = rdata_q;
  assign irq             = irq_q;
  assign cop_hold        = cfg_q[CFG_HOLD];
  assign cop_reset_pulse = rstp_q;

endmodule

// File: rtl/hdp_engine_chk.sv
module hdp_engine_chk #(
  parameter int DW  = 16,
  parameter int AW  = 16,
  parameter int RAW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          host_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_we,
  input logic [1:0]    mem_space,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          fifo_full,
  input logic          fifo_push,
  input logic [AW-1:0] addr_q,
  input logic          autoinc,
  input logic          cop_reset_pulse,
  input logic          cop_hold
);

  a_r11_req_stable: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_we) &&
       $stable(mem_space) && $stable(mem_wdata)));

  a_r1_regs_addr_range: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_space == 2'd1) |-> ((mem_addr >> RAW) == '0));

  a_r4_busy_while_requesting: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !host_ready);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !fifo_push);

  a_r2_step_after_access: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready && autoinc) |=> (addr_q == $past(addr_q) + 1'b1));

  a_r10_pulse_with_hold: assert property (@(posedge clk) disable iff (rst)
    cop_reset_pulse |-> cop_hold);

endmodule

bind hdp_engine hdp_engine_chk #(.DW(DW), .AW(AW), .RAW(RAW)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .host_ready      (host_ready),
  .mem_req_valid   (mem_req_valid),
  .mem_req_ready   (mem_req_ready),
  .mem_we          (mem_we),
  .mem_space       (mem_space),
  .mem_addr        (mem_addr),
  .mem_wdata       (mem_wdata),
  .fifo_full       (fifo_full),
  .fifo_push       (fifo_push),
  .addr_q          (addr_q),
  .autoinc         (cfg_q[1]),
  .cop_reset_pulse (cop_reset_pulse),
  .cop_hold        (cop_hold)
);

// File: tb/hdp_engine_test.sv
module hdp_engine_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [15:0] host_wdata = 16'd0;
  logic        host_ready, host_rvalid, irq, cop_hold, cop_reset_pulse;
  logic [15:0] host_rdata;
  logic        mem_req_valid, mem_we;
  logic        mem_req_ready = 1'b1;
  logic [1:0]  mem_space;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = 16'hDEAD;

  always #5 clk = ~clk;

  hdp_engine uut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_ready(host_ready), .host_rvalid(host_rvalid),
    .host_rdata(host_rdata), .irq(irq), .cop_hold(cop_hold), .cop_reset_pulse(cop_reset_pulse),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
    .mem_space(mem_space), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  int irq_seen = 0;
  int pulse_seen = 0;
  int wr_cnt = 0;
  logic [1:0]  wr_sp;
  logic [15:0] wr_addr, wr_data;
  bit   stall_mode = 1'b0;

  // bench model
  int          mq[$];
  int          m_rem = 0;
  bit          m_endless = 1'b0;
  logic [15:0] m_addr = 16'd0;
  logic [15:0] m_cfg = 16'd0;
  int          m_irq = 0;
  int          m_pulse = 0;
  int          m_wr = 0;

  function automatic logic [15:0] mem_val(input logic [1:0] sp, input logic [15:0] a);
    return (a * 16'd3 + {sp, 14'd0} + {14'd0, sp}) ^ 16'hA5C3;
  endfunction

  // returns -1 for codes that make no access
  function automatic int space_of(input logic [2:0] code);
    case (code)
      3'd0: return 0;
      3'd1: return 1;
      3'd5: return 2;
      3'd7: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [15:0] phys_addr(input logic [2:0] code, input logic [15:0] a);
    return (code == 3'd1) ? (a & 16'h07FF) : a;
  endfunction

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready && !mem_we) mem_rdata <= mem_val(mem_space, mem_addr);
    else mem_rdata <= 16'hDEAD;
    if (mem_req_valid && mem_req_ready && mem_we) begin
      wr_cnt  <= wr_cnt + 1;
      wr_sp   <= mem_space;
      wr_addr <= mem_addr;
      wr_data <= mem_wdata;
    end
    if (!rst && irq) irq_seen <= irq_seen + 1;
    if (!rst && cop_reset_pulse) pulse_seen <= pulse_seen + 1;
  end

  always @(negedge clk) begin
    if (stall_mode) mem_req_ready <= ($urandom % 3) != 0;
    else            mem_req_ready <= 1'b1;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_op(input bit we, input logic [1:0] sel, input logic [15:0] wd,
                         output logic [15:0] rd);
    rd = 16'h0;
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_we = we; host_sel = sel; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    if (!we) begin
      while (!host_rvalid) @(negedge clk);
      rd = host_rdata;
    end
    while (!host_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic model_fetch();
    int sp;
    sp = space_of(m_cfg[14:12]);
    if (sp >= 0) begin
      mq.push_back(int'(mem_val(2'(sp), phys_addr(m_cfg[14:12], m_addr))));
      if (m_cfg[1]) m_addr = m_addr + 16'd1;
    end else begin
      mq.push_back(0);
    end
    if (!m_endless) m_rem--;
  endtask

  function automatic int quota_of(input int free);
    if (m_endless || free < m_rem) return free;
    return m_rem;
  endfunction

  task automatic do_cfg(input logic [15:0] v);
    logic [15:0] rd;
    int n;
    m_cfg = v;
    mq.delete();
    if (v[0]) m_pulse++;
    if (v[4]) begin
      m_endless = (v[3:2] == 2'd3);
      case (v[3:2])
        2'd0: m_rem = 1;
        2'd1: m_rem = 8;
        2'd2: m_rem = 16;
        default: m_rem = 0;
      endcase
      n = quota_of(16);
      for (int i = 0; i < n; i++) model_fetch();
      m_irq++;
    end else begin
      m_rem = 0;
      m_endless = 1'b0;
    end
    host_op(1'b1, 2'd2, v, rd);
  endtask

  task automatic do_pop(input string req);
    logic [15:0] rd;
    logic [15:0] exp;
    int n;
    if (m_endless || m_rem > 0) begin
      n = quota_of(16 - mq.size());
      for (int i = 0; i < n; i++) model_fetch();
      exp = 16'(mq.pop_front());
      if (mq.size() > 0) m_irq++;
    end else if (mq.size() > 0) begin
      exp = 16'(mq.pop_front());
      if (mq.size() > 0) m_irq++;
    end else begin
      exp = 16'h0000;
    end
    host_op(1'b0, 2'd0, 16'h0, rd);
    check(req, rd, exp);
  endtask

  task automatic do_dwrite(input logic [15:0] v);
    logic [15:0] rd;
    int sp;
    logic [15:0] pa;
    sp = space_of(m_cfg[14:12]);
    pa = phys_addr(m_cfg[14:12], m_addr);
    host_op(1'b1, 2'd0, v, rd);
    if (sp >= 0) begin
      m_wr++;
      m_irq++;
      if (m_cfg[1]) m_addr = m_addr + 16'd1;
      check("R13 write space", {14'd0, wr_sp}, 16'(sp));
      check("R13 write addr", wr_addr, pa);
      check("R13 write data", wr_data, v);
    end
    check("R1 write count", 16'(wr_cnt), 16'(m_wr));
  endtask

  task automatic do_stat(input string req);
    logic [15:0] rd;
    logic [15:0] exp;
    exp = 16'h0100;
    if (mq.size() > 0) exp = exp | 16'h0041;
    if (mq.size() == 16) exp = exp | 16'h0020;
    host_op(1'b0, 2'd3, 16'h0, rd);
    check(req, rd, exp);
  endtask

  task automatic do_addr_wr(input logic [15:0] v);
    logic [15:0] rd;
    m_addr = v;
    host_op(1'b1, 2'd1, v, rd);
  endtask

  task automatic do_addr_rd(input string req);
    logic [15:0] rd;
    host_op(1'b0, 2'd1, 16'h0, rd);
    check(req, rd, m_addr);
  endtask

  task automatic check_events();
    check("R9 irq count", 16'(irq_seen), 16'(m_irq));
    check("R10 pulse count", 16'(pulse_seen), 16'(m_pulse));
    check("R10 hold level", {15'd0, cop_hold}, {15'd0, m_cfg[0]});
  endtask

  function automatic logic [15:0] cfg_word(input logic [2:0] reg_code, input bit start,
                                           input logic [1:0] len, input bit ainc, input bit hold);
    return {1'b0, reg_code, 7'd0, start, len, ainc, hold};
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12: reset state
    check("R12 rvalid", {15'd0, host_rvalid}, 16'd0);
    check("R12 irq", {15'd0, irq}, 16'd0);
    check("R12 ready", {15'd0, host_ready}, 16'd1);
    do_stat("R12 status");
    host_op(1'b0, 2'd2, 16'h0, rd);
    check("R12 config", rd, 16'h0000);
    do_addr_rd("R12 address");
    do_pop("R7 empty pop after reset");

    // R3/R4/R8: 16-word burst, data memory, autoinc
    do_addr_wr(16'h0100);
    do_cfg(cfg_word(3'd0, 1'b1, 2'd2, 1'b1, 1'b0));
    do_stat("R8 full after 16-word start");
    check_events();
    for (int i = 0; i < 16; i++) do_pop("R6 pop of 16-word burst");
    do_pop("R7 pop after burst drained");
    do_addr_rd("R2 address after 16 fetches");

    // R3: 8-word burst, program memory
    do_cfg(cfg_word(3'd5, 1'b1, 2'd1, 1'b1, 1'b0));
    do_stat("R8 not full after 8-word start");
    for (int i = 0; i < 9; i++) do_pop("R3 8-word burst");

    // R3: single word, no autoinc
    do_addr_wr(16'h0042);
    do_cfg(cfg_word(3'd7, 1'b1, 2'd0, 1'b0, 1'b0));
    do_pop("R3 single-word burst");
    do_pop("R7 pop with nothing owed");
    do_addr_rd("R2 no step without autoinc");

    // R2/R1: endless stream in register space across the wrap
    do_addr_wr(16'hFFF8);
    do_cfg(cfg_word(3'd1, 1'b1, 2'd3, 1'b1, 1'b0));
    for (int i = 0; i < 24; i++) do_pop("R1 register-space stream");
    do_addr_rd("R2 wrap of address");
    check_events();

    // R5: cancel
    do_cfg(cfg_word(3'd1, 1'b0, 2'd3, 1'b1, 1'b0));
    do_stat("R5 status after cancel");
    do_pop("R5 pop after cancel");

    // R1: invalid region fills zeros, no access
    do_addr_wr(16'h0200);
    do_cfg(cfg_word(3'd3, 1'b1, 2'd1, 1'b1, 1'b0));
    do_pop("R1 invalid region gives zero");
    do_addr_rd("R1 invalid region keeps address");
    do_dwrite(16'h1234);

    // R13/R10: writes and hold
    do_cfg(cfg_word(3'd0, 1'b0, 2'd0, 1'b1, 1'b1));
    do_dwrite(16'hBEEF);
    do_dwrite(16'h0F0F);
    check_events();

    // random phase with backpressure
    stall_mode = 1'b1;
    for (int k = 0; k < 500; k++) begin
      int op;
      op = $urandom % 10;
      case (op)
        0, 1: begin
          logic [2:0] rc;
          int pick;
          pick = $urandom % 5;
          rc = (pick == 0) ? 3'd0 : (pick == 1) ? 3'd1 : (pick == 2) ? 3'd5 :
               (pick == 3) ? 3'd7 : 3'd2;
          do_cfg(cfg_word(rc, ($urandom % 4) != 0, 2'($urandom % 4), 1'($urandom % 2),
                          ($urandom % 8) == 0));
        end
        2, 3, 4, 5: do_pop("R6 random pop");
        6: do_dwrite(16'($urandom));
        7: do_stat("R8 random status");
        8: begin
          if ($urandom % 2) do_addr_wr(16'hFFF0 + 16'($urandom % 16));
          else              do_addr_wr(16'($urandom));
        end
        default: do_addr_rd("R2 random address");
      endcase
      check_events();
    end
    stall_mode = 1'b0;
    do_stat("R11 final status");
    finish_run();
  end

endmodule